// File: doc/BRIEF.md
# Three-Client Time-Sliced RAM Arbiter with Double-Buffered Framebuffer

This block lets three clients share one single-port RAM through a fixed, repeating rotation of two-cycle access slots. The clients are a display refresh reader, a blitter that draws into an off-screen framebuffer, and a CPU port. The rotation is display, blitter, CPU, and it repeats every six cycles whether or not anyone has work. A slot nobody claims leaves the RAM idle, so the timing of each client never depends on what the other two are doing.

The block also keeps track of two framebuffers. The display always fetches through the front buffer's base address and the blitter always writes through the back buffer's base address. Both clients give offsets, not absolute addresses. When the blitter signals that a frame is finished, the swap is held pending and takes place at the next vertical-blank pulse. The two buffers then exchange roles and the new image appears without tearing. The CPU uses absolute addresses.

Clients hold their request until they receive a one-cycle valid strobe. For reads, the strobe comes with the data. For writes, it acknowledges the write. The RAM is synchronous, with one cycle of read latency, and is driven through address, write-data, write-enable and read-data ports. The memory side is intended for a 50 MHz clock.

Top module: `ramSlotArbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `frontSel` is 0 (buffer 0 is front), all three valid strobes are 0 and `ramWe` is 0. Counting from the first cycle with `rst` low as cycle 0, the display owns the slot that starts in cycle 0.
- R2: Slots rotate in the fixed order display, blitter, CPU. Each slot is two cycles long. A client's request is sampled, and its address is put on `ramAddr`, only in the first cycle of its own slot, which is cycle 6n for the display, 6n+2 for the blitter and 6n+4 for the CPU. The CPU address goes to `ramAddr` unchanged.
- R3: If a client has no request in the first cycle of its slot, `ramWe` stays 0 for that slot and no valid strobe follows. The slot is never given to another client.
- R4: A granted access produces exactly one one-cycle valid strobe for its client, two cycles after its slot starts, which is the cycle after the slot ends. At most one of the three valid strobes is high in any cycle.
- R5: `dispData` and `cpuRdData` are valid while their strobe is high. Each holds the RAM contents at the requested address as they were when the slot started.
- R6: A display fetch addresses the front base plus `dispOfs`, and a blitter write addresses the back base plus `blitOfs`. Buffer 0 is based at `BUF0_BASE` and buffer 1 at `BUF1_BASE`. `frontSel`=0 means buffer 0 is front and buffer 1 is back. `frontSel`=1 means the reverse.
- R7: `ramWe` is high for exactly one cycle, the first cycle of the slot, for every granted blitter request and for every granted CPU request with `cpuWe`=1. In that cycle `ramWrData` carries the client's write data.
- R8: A `blitDone` pulse marks a swap as pending. `frontSel` toggles on the edge that ends the first later cycle in which `vblank` is high, and it changes at no other time. A `blitDone` that arrives in the same cycle as that `vblank` waits for the following `vblank`.
- R9: Several `blitDone` pulses before one `vblank` cause only one swap. A `vblank` with no swap pending leaves `frontSel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank | input | 1 | Vertical-blank pulse, one cycle per frame |
| dispReq | input | 1 | Display read request, held until dispValid |
| dispOfs | input | OFS_W | Offset into the front buffer |
| dispValid | output | 1 | One-cycle display read strobe |
| dispData | output | DATA_W | Display read data |
| blitReq | input | 1 | Blitter write request, held until blitValid |
| blitOfs | input | OFS_W | Offset into the back buffer |
| blitWrData | input | DATA_W | Blitter write data |
| blitDone | input | 1 | Pulse: back buffer fully rendered |
| blitValid | output | 1 | One-cycle blitter write acknowledge |
| cpuReq | input | 1 | CPU access request, held until cpuValid |
| cpuAddr | input | ADDR_W | CPU absolute address |
| cpuWe | input | 1 | CPU access is a write |
| cpuWrData | input | DATA_W | CPU write data |
| cpuValid | output | 1 | One-cycle CPU strobe (read data or write acknowledge) |
| cpuRdData | output | DATA_W | CPU read data |
| ramAddr | output | ADDR_W | RAM address |
| ramWe | output | 1 | RAM write enable |
| ramWrData | output | DATA_W | RAM write data |
| ramRdData | input | DATA_W | RAM read data, one cycle after the address |
| frontSel | output | 1 | Buffer currently shown (0 or 1) |

## Verification
The bound checker watches every cycle for the following: the valid strobes are mutually exclusive and one cycle long, a display strobe is followed by five quiet cycles, every write pulse lasts one cycle and belongs to a client that asked to write, and `frontSel` changes only right after a `vblank`. Some behaviour can only be shown by the bench's reference model, which follows the slot position, a shadow of memory and the pending-swap state: the exact slot-start cycle of each grant, the front-based and back-based addresses, the returned data, and the swap cases. The swap cases are a deferred swap, several `blitDone` pulses folded into one swap, an idle `vblank`, and a `blitDone` that coincides with `vblank`.

// File: rtl/ramSlotPkg.sv
package ramSlotPkg;
  localparam int NUM_CLIENTS = 3;
  localparam int CL_DISP = 0;
  localparam int CL_BLIT = 1;
  localparam int CL_CPU  = 2;

  typedef struct packed {
    logic [NUM_CLIENTS-1:0] launch;   // first cycle of a granted slot
    logic [NUM_CLIENTS-1:0] capture;  // last cycle of a granted slot
    logic                   frontSel;
  } slotCtrl_t;
endpackage

// File: rtl/slotControl.sv
module slotControl
  import ramSlotPkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vblank,
  input  logic                   blitDone,
  input  logic [NUM_CLIENTS-1:0] reqVec,
  output slotCtrl_t              ctrl
);
  localparam int OWN_W = $clog2(NUM_CLIENTS);
  localparam logic [OWN_W-1:0] LAST_OWNER = OWN_W'(NUM_CLIENTS - 1);

  logic [OWN_W-1:0]       owner;
  logic                   phase;
  logic [NUM_CLIENTS-1:0] busy;
  logic                   front;
  logic                   swapPending;

  always_comb begin
    for (int k = 0; k < NUM_CLIENTS; k++) begin
      ctrl.launch[k]  = !rst && !phase && (owner == OWN_W'(k)) && reqVec[k];
      ctrl.capture[k] = phase && busy[k];
    end
    ctrl.frontSel = front;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner       <= '0;
      phase       <= 1'b0;
      busy        <= '0;
      front       <= 1'b0;
      swapPending <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) owner <= (owner == LAST_OWNER) ? '0 : owner + 1'b1;
      busy <= ctrl.launch;
      if (vblank && swapPending) begin
        front       <= ~front;
        swapPending <= blitDone;
      end else if (blitDone) begin
        swapPending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/slotDatapath.sv
module slotDatapath
  import ramSlotPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 10,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BUF0_BASE = 12'h400,
  parameter logic [ADDR_W-1:0] BUF1_BASE = 12'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  slotCtrl_t         ctrl,
  input  logic [OFS_W-1:0]  dispOfs,
  input  logic [OFS_W-1:0]  blitOfs,
  input  logic [DATA_W-1:0] blitWrData,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWrData,
  output logic              dispValid,
  output logic [DATA_W-1:0] dispData,
  output logic              blitValid,
  output logic              cpuValid,
  output logic [DATA_W-1:0] cpuRdData
);
  logic [ADDR_W-1:0] frontBase, backBase, launchAddr, heldAddr;
  logic [NUM_CLIENTS-1:0] validQ;

  always_comb begin
    frontBase = ctrl.frontSel ? BUF1_BASE : BUF0_BASE;
    backBase  = ctrl.frontSel ? BUF0_BASE : BUF1_BASE;
    unique case (1'b1)
      ctrl.launch[CL_DISP]: launchAddr = frontBase + ADDR_W'(dispOfs);
      ctrl.launch[CL_BLIT]: launchAddr = backBase + ADDR_W'(blitOfs);
      ctrl.launch[CL_CPU]:  launchAddr = cpuAddr;
      default:              launchAddr = heldAddr;
    endcase
    ramAddr   = launchAddr;
    ramWe     = ctrl.launch[CL_BLIT] || (ctrl.launch[CL_CPU] && cpuWe);
    ramWrData = ctrl.launch[CL_BLIT] ? blitWrData :
                ctrl.launch[CL_CPU]  ? cpuWrData  : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldAddr  <= '0;
      validQ    <= '0;
      dispData  <= '0;
      cpuRdData <= '0;
    end else begin
      if (|ctrl.launch) heldAddr <= launchAddr;
      validQ <= ctrl.capture;
      if (ctrl.capture[CL_DISP]) dispData  <= ramRdData;
      if (ctrl.capture[CL_CPU])  cpuRdData <= ramRdData;
    end
  end

  assign dispValid = validQ[CL_DISP];
  assign blitValid = validQ[CL_BLIT];
  assign cpuValid  = validQ[CL_CPU];
endmodule

// File: rtl/ramSlotArbiter.sv
module ramSlotArbiter
  import ramSlotPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 10,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BUF0_BASE = 12'h400,
  parameter logic [ADDR_W-1:0] BUF1_BASE = 12'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vblank,
  input  logic              dispReq,
  input  logic [OFS_W-1:0]  dispOfs,
  output logic              dispValid,
  output logic [DATA_W-1:0] dispData,
  input  logic              blitReq,
  input  logic [OFS_W-1:0]  blitOfs,
  input  logic [DATA_W-1:0] blitWrData,
  input  logic              blitDone,
  output logic              blitValid,
  input  logic              cpuReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic              cpuValid,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              frontSel
);
  slotCtrl_t ctrl;
  logic [NUM_CLIENTS-1:0] reqVec;

  always_comb begin
    reqVec = '0;
    reqVec[CL_DISP] = dispReq;
    reqVec[CL_BLIT] = blitReq;
    reqVec[CL_CPU]  = cpuReq;
  end

  slotControl uCtrl (
    .clk(clk), .rst(rst), .vblank(vblank), .blitDone(blitDone),
    .reqVec(reqVec), .ctrl(ctrl)
  );

  slotDatapath #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W),
    .BUF0_BASE(BUF0_BASE), .BUF1_BASE(BUF1_BASE)
  ) uPath (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .dispOfs(dispOfs), .blitOfs(blitOfs), .blitWrData(blitWrData),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuWrData(cpuWrData),
    .ramRdData(ramRdData), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramWrData(ramWrData), .dispValid(dispValid), .dispData(dispData),
    .blitValid(blitValid), .cpuValid(cpuValid), .cpuRdData(cpuRdData)
  );

  assign frontSel = ctrl.frontSel;
endmodule

// File: rtl/ramSlotChecker.sv
module ramSlotChecker (
  input logic clk,
  input logic rst,
  input logic vblank,
  input logic blitReq,
  input logic cpuReq,
  input logic cpuWe,
  input logic ramWe,
  input logic dispValid,
  input logic blitValid,
  input logic cpuValid,
  input logic frontSel
);
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  // R1: one edge after reset is seen, the block is in its reset state
  always @(posedge clk)
    if (rstSeen)
      assert_reset_state_R1: assert (!frontSel && !ramWe && !dispValid && !blitValid && !cpuValid);

  assert_valid_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dispValid, blitValid, cpuValid}));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (blitValid || cpuValid) |=> !(blitValid || cpuValid) || (blitValid != $past(blitValid)));

  assert_disp_rotation_R2: assert property (@(posedge clk) disable iff (rst)
    dispValid |=> !dispValid [*5]);

  assert_no_idle_write_R3: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> (blitReq || (cpuReq && cpuWe)));

  assert_write_single_R7: assert property (@(posedge clk) disable iff (rst)
    ramWe |=> !ramWe);

  assert_swap_on_vblank_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(frontSel) |-> $past(vblank));
endmodule

bind ramSlotArbiter ramSlotChecker uChk (
  .clk(clk), .rst(rst), .vblank(vblank), .blitReq(blitReq), .cpuReq(cpuReq),
  .cpuWe(cpuWe), .ramWe(ramWe), .dispValid(dispValid), .blitValid(blitValid),
  .cpuValid(cpuValid), .frontSel(frontSel)
);

// File: tb/sim_ramSlotArbiter.sv
`timescale 1ns/1ps
module sim_ramSlotArbiter;
  localparam int ADDR_W = 12;
  localparam int OFS_W  = 10;
  localparam int DATA_W = 8;
  localparam int B0 = 'h400;
  localparam int B1 = 'h800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vblank = 0, dispReq = 0, blitReq = 0, blitDone = 0, cpuReq = 0, cpuWe = 0;
  logic [OFS_W-1:0] dispOfs = '0, blitOfs = '0;
  logic [DATA_W-1:0] blitWrData = '0, cpuWrData = '0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic dispValid, blitValid, cpuValid, ramWe, frontSel;
  logic [DATA_W-1:0] dispData, cpuRdData, ramWrData, ramRdData;
  logic [ADDR_W-1:0] ramAddr;

  always #2 clk = ~clk;

  ramSlotArbiter u0 (
    .clk(clk), .rst(rst), .vblank(vblank),
    .dispReq(dispReq), .dispOfs(dispOfs), .dispValid(dispValid), .dispData(dispData),
    .blitReq(blitReq), .blitOfs(blitOfs), .blitWrData(blitWrData), .blitDone(blitDone),
    .blitValid(blitValid), .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuWrData(cpuWrData), .cpuValid(cpuValid), .cpuRdData(cpuRdData),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWrData(ramWrData), .ramRdData(ramRdData),
    .frontSel(frontSel)
  );

  // behavioural RAM
  logic [DATA_W-1:0] ram [1<<ADDR_W];
  always_ff @(posedge clk) begin
    if (ramWe) ram[ramAddr] <= ramWrData;
    ramRdData <= ram[ramAddr];
  end

  // reference model state
  int checks = 0, fails = 0, cyc = 0;
  logic [DATA_W-1:0] shadow [1<<ADDR_W];
  int lcyc [3];
  int expD [3];
  bit refFront = 0, refPend = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic checkCycle();
    int p, own, addr, wd;
    bit first, lnch, expWe, expV;
    bit [2:0] vals;
    if (rst) begin
      chk(!frontSel && !ramWe && !dispValid && !blitValid && !cpuValid, "R1 reset state",
          {frontSel, ramWe, dispValid, blitValid, cpuValid}, 0);
      cyc = 0; refFront = 0; refPend = 0;
      for (int k = 0; k < 3; k++) lcyc[k] = -100;
      return;
    end
    p = cyc % 6; own = p / 2; first = (p % 2 == 0);
    lnch = 0; expWe = 0; addr = 0; wd = 0;
    if (first) begin
      case (own)
        0: if (dispReq) begin lnch = 1; addr = (refFront ? B1 : B0) + int'(dispOfs); end
        1: if (blitReq) begin lnch = 1; addr = (refFront ? B0 : B1) + int'(blitOfs);
                              expWe = 1; wd = int'(blitWrData); end
        default: if (cpuReq) begin lnch = 1; addr = int'(cpuAddr); expWe = cpuWe;
                                   wd = int'(cpuWrData); end
      endcase
    end
    if (expWe) chk(ramWe == 1'b1, "R7 write strobe", ramWe, 1);
    else       chk(ramWe == 1'b0, "R3 no write in idle or read slot", ramWe, 0);
    if (lnch) chk(int'(ramAddr) == addr, own == 2 ? "R2 cpu slot address" : "R6 buffer address",
                  int'(ramAddr), addr);
    if (expWe) chk(int'(ramWrData) == wd, "R7 write data", int'(ramWrData), wd);
    vals = {cpuValid, blitValid, dispValid};
    for (int k = 0; k < 3; k++) begin
      expV = (cyc == lcyc[k] + 2);
      chk(vals[k] == expV, "R4 valid strobe timing", vals[k], expV);
    end
    if (dispValid && cyc == lcyc[0] + 2)
      chk(int'(dispData) == expD[0], "R5 display data", int'(dispData), expD[0]);
    if (cpuValid && cyc == lcyc[2] + 2)
      chk(int'(cpuRdData) == expD[2], "R5 cpu data", int'(cpuRdData), expD[2]);
    chk(frontSel == refFront, "R8 front selection", frontSel, refFront);
    // advance model past this edge
    if (lnch) begin
      lcyc[own] = cyc;
      expD[own] = int'(shadow[addr]);
      if (expWe) shadow[addr] = DATA_W'(wd);
    end
    if (vblank && refPend) begin refFront = !refFront; refPend = blitDone; end
    else if (blitDone) refPend = 1;
    cyc++;
  endtask

  task automatic tick();
    #1;
    checkCycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    dispReq = 0; blitReq = 0; cpuReq = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic dispRead(int ofs, output int data);
    int guard = 0;
    dispReq = 1; dispOfs = OFS_W'(ofs);
    do begin tick(); guard++; end while (!dispValid && guard < 20);
    data = int'(dispData); dispReq = 0;
  endtask

  task automatic blitWrite(int ofs, int data);
    int guard = 0;
    blitReq = 1; blitOfs = OFS_W'(ofs); blitWrData = DATA_W'(data);
    do begin tick(); guard++; end while (!blitValid && guard < 20);
    blitReq = 0;
  endtask

  task automatic cpuAccess(int a, bit we, int wdat, output int data);
    int guard = 0;
    cpuReq = 1; cpuAddr = ADDR_W'(a); cpuWe = we; cpuWrData = DATA_W'(wdat);
    do begin tick(); guard++; end while (!cpuValid && guard < 20);
    data = int'(cpuRdData); cpuReq = 0; cpuWe = 0;
  endtask

  task automatic pulseVblank(bit withDone);
    vblank = 1; blitDone = withDone; tick(); vblank = 0; blitDone = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired (cycle %0d)", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int d;
    int unsigned seed = 32'h1234_5678;
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      ram[a] = DATA_W'(a * 37 + 11);
      shadow[a] = DATA_W'(a * 37 + 11);
    end
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick();     // R1 during reset
    rst = 0;
    tick();                                  // R1 first cycle after reset
    idle(11);                                // R3 idle slots

    dispRead(10, d);                         // R5, R6 front = buffer 0
    chk(d == ((B0 + 10) * 37 + 11) % 256, "R5 display read of buffer 0", d, ((B0 + 10) * 37 + 11) % 256);
    blitWrite(10, 'hA5);                     // R6 back = buffer 1
    cpuAccess('h123, 1, 'h3C, d);            // R7
    cpuAccess('h123, 0, 0, d);
    chk(d == 'h3C, "R5 cpu readback", d, 'h3C);

    // R2 all clients busy, addresses changing every cycle
    dispReq = 1; blitReq = 1; cpuReq = 1;
    for (int i = 0; i < 48; i++) begin
      seed = seed * 1103515245 + 12345;
      dispOfs = OFS_W'(seed >> 8); blitOfs = OFS_W'(seed >> 4);
      blitWrData = DATA_W'(seed >> 20); cpuAddr = ADDR_W'(seed >> 12);
      cpuWe = seed[27]; cpuWrData = DATA_W'(seed >> 24);
      tick();
    end
    idle(6);
    blitWrite(10, 'hA5);

    // R8 deferred swap
    blitDone = 1; tick(); blitDone = 0;
    idle(4);
    chk(frontSel == 0, "R8 no swap before vblank", frontSel, 0);
    pulseVblank(0);
    chk(frontSel == 1, "R8 swap at vblank", frontSel, 1);
    dispRead(10, d);
    chk(d == 'hA5, "R6 display reads rendered buffer after swap", d, 'hA5);

    // R9 several done pulses fold into one swap
    blitDone = 1; tick(); tick(); blitDone = 0; tick();
    blitDone = 1; tick(); blitDone = 0;
    pulseVblank(0);
    chk(frontSel == 0, "R9 single swap for many done pulses", frontSel, 0);
    idle(3);
    pulseVblank(0);
    chk(frontSel == 0, "R9 idle vblank keeps front", frontSel, 0);

    // R8 done coincident with vblank waits for next vblank
    pulseVblank(1);
    chk(frontSel == 0, "R8 coincident done not swapped yet", frontSel, 0);
    idle(5);
    pulseVblank(0);
    chk(frontSel == 1, "R8 coincident done swapped next vblank", frontSel, 1);
    idle(6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule